// File: doc/BRIEF.md
# Reset cause and software reset registers

This block is a small 32-bit register file that sits inside a reset manager. It keeps a record of why the device last came out of reset: a set of sticky flags, one per cause. Hardware raises a flag with a single-cycle pulse, and software reads the flags and clears them. Several flags may be set at once.

The block also provides two software-controlled, active-low peripheral reset lines. The first is for an SPI device and the second is for a USB peripheral. Each line is driven by a control bit. Each control bit is guarded by its own lock bit. Software may clear a lock bit, but only a full reset sets it again. Once a lock is cleared, its control bit is frozen.

Software reaches the registers through a plain register port made of valid, write, address and write data. Read data comes back on the cycle after the read request.

Top module: `rstc_regs`

## Requirements
- R1: After reset, the cause field reads 0x01. Both lock bits and both control bits read 1. Both reset outputs are 1, and `rsp_rdata_o` is 0.
- R2: A pulse on `cause_pulse_i` sets the matching flags in the cause register at offset 0x00 on the next clock. The bit positions are: bit 0 power-up, bit 1 low-power exit, bit 2 watchdog, bit 3 security escalation, bit 4 non-debug-module request. Flags are sticky and several may be set together.
- R3: A write to offset 0x00 clears each cause flag whose write-data bit is 1. Flags whose write-data bit is 0 are unchanged, and write-data bits 31:5 have no effect.
- R4: If a cause pulse and a clearing write hit the same flag in the same cycle, the flag stays set.
- R5: Each lock bit sits at bit 0 of its register: offset 0x04 for SPI and 0x0C for USB. A write with bit 0 equal to 1 clears the lock. A write with bit 0 equal to 0 has no effect. No write can set a cleared lock again.
- R6: While a lock bit is 1, a write to its control register loads write-data bit 0 into the control bit. The control register is at offset 0x08 for SPI and 0x10 for USB.
- R7: While a lock bit is 0, a write to its control register is ignored.
- R8: `periph_rst_no[0]` (SPI) and `periph_rst_no[1]` (USB) equal their control bits delayed by one clock. A value of 0 holds the peripheral in reset.
- R9: A read at cycle t returns the register value as it was at cycle t, on `rsp_rdata_o` at cycle t+1, with unused bits 0. `rsp_rdata_o` is 0 in any cycle that follows a cycle with no read.
- R10: A read of any unmapped offset returns 0. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_vld_i | input | 1 | Register access request |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, one cycle after the request |
| cause_pulse_i | input | 5 | Single-cycle reset-cause pulses, one bit per cause |
| periph_rst_no | output | 2 | Active-low peripheral resets: bit 0 SPI, bit 1 USB |

## Verification
The bench builds the block with its default parameters: five causes, two lock/control channels, an 8-bit address and a 32-bit data path. The 8-bit address lets the bench reach unmapped offsets just past the map, at misaligned positions, and at the very top of the space. The two channels let it show that clearing one lock leaves the other channel writable. Running five causes over the full data width shows that the upper write-data bits neither clear a flag nor appear in the read data.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  // Offset of the cause register and layout of the lock/control channels
  localparam int unsigned CAUSE_OFS = 0;
  localparam int unsigned LOCK_BASE = 4;
  localparam int unsigned CTRL_BASE = 8;
  localparam int unsigned CH_STRIDE = 8;

  // Bit index of each reset cause inside the cause field
  typedef enum int unsigned {
    CAUSE_POWER_UP  = 0,
    CAUSE_LP_EXIT   = 1,
    CAUSE_WATCHDOG  = 2,
    CAUSE_ESCALATE  = 3,
    CAUSE_NDM_REQ   = 4
  } cause_idx_e;

  function automatic int unsigned lock_ofs(input int unsigned ch);
    return LOCK_BASE + ch * CH_STRIDE;
  endfunction

  function automatic int unsigned ctrl_ofs(input int unsigned ch);
    return CTRL_BASE + ch * CH_STRIDE;
  endfunction
endpackage

// File: rtl/rstc_cause.sv
module rstc_cause #(
  parameter int unsigned NUM_CAUSE = 5,
  parameter logic [NUM_CAUSE-1:0] RST_VAL = NUM_CAUSE'(1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_en_i,
  input  logic [NUM_CAUSE-1:0] clr_mask_i,
  input  logic [NUM_CAUSE-1:0] set_i,
  output logic [NUM_CAUSE-1:0] cause_o
);
  logic [NUM_CAUSE-1:0] cause_q, cause_d;
  logic                 cause_en;

  // Clear first, then set, so a same-cycle pulse wins
  always_comb begin
    cause_d = cause_q;
    if (clr_en_i) cause_d = cause_d & ~clr_mask_i;
    cause_d  = cause_d | set_i;
    cause_en = clr_en_i | (|set_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cause_q <= RST_VAL;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rstc_swrst.sv
module rstc_swrst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_wr_i,
  input  logic ctrl_wr_i,
  input  logic wbit_i,
  output logic lock_o,
  output logic ctrl_o,
  output logic rst_no
);
  logic lock_q, lock_d, lock_en;
  logic ctrl_q, ctrl_d, ctrl_en;
  logic rst_nq;

  always_comb begin
    lock_en = lock_wr_i & wbit_i;
    lock_d  = 1'b0;
    ctrl_en = ctrl_wr_i & lock_q;
    ctrl_d  = wbit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lock_q <= 1'b1;
    else if (lock_en) lock_q <= lock_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= 1'b1;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_nq <= 1'b1;
    else         rst_nq <= ctrl_q;
  end

  assign lock_o = lock_q;
  assign ctrl_o = ctrl_q;
  assign rst_no = rst_nq;
endmodule

// File: rtl/rstc_rdmux.sv
module rstc_rdmux
  import rstc_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_CAUSE = 5,
  parameter int unsigned NUM_SW    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_CAUSE-1:0] cause_i,
  input  logic [NUM_SW-1:0]    lock_i,
  input  logic [NUM_SW-1:0]    ctrl_i,
  output logic [DATA_W-1:0]    rdata_o
);
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = '0;
    if (rd_en_i) begin
      if (addr_i == ADDR_W'(CAUSE_OFS)) rdata_d[NUM_CAUSE-1:0] = cause_i;
      for (int unsigned k = 0; k < NUM_SW; k++) begin
        if (addr_i == ADDR_W'(lock_ofs(k))) rdata_d[0] = lock_i[k];
        if (addr_i == ADDR_W'(ctrl_ofs(k))) rdata_d[0] = ctrl_i[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rstc_regs.sv
module rstc_regs
  import rstc_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_CAUSE = 5,
  parameter int unsigned NUM_SW    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_vld_i,
  input  logic                 req_wr_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  output logic [DATA_W-1:0]    rsp_rdata_o,
  input  logic [NUM_CAUSE-1:0] cause_pulse_i,
  output logic [NUM_SW-1:0]    periph_rst_no
);
  localparam logic [NUM_CAUSE-1:0] CAUSE_RST = NUM_CAUSE'(1) << CAUSE_POWER_UP;

  logic                 wr_acc, rd_acc, cause_clr;
  logic [NUM_CAUSE-1:0] cause_q;
  logic [NUM_SW-1:0]    lock_q, ctrl_q, lock_wr, ctrl_wr;
  logic                 unused_wdata;

  assign wr_acc       = req_vld_i & req_wr_i;
  assign rd_acc       = req_vld_i & ~req_wr_i;
  assign cause_clr    = wr_acc & (req_addr_i == ADDR_W'(CAUSE_OFS));
  assign unused_wdata = ^req_wdata_i[DATA_W-1:NUM_CAUSE];

  rstc_cause #(
    .NUM_CAUSE (NUM_CAUSE),
    .RST_VAL   (CAUSE_RST)
  ) u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_en_i   (cause_clr),
    .clr_mask_i (req_wdata_i[NUM_CAUSE-1:0]),
    .set_i      (cause_pulse_i),
    .cause_o    (cause_q)
  );

  for (genvar k = 0; k < NUM_SW; k++) begin : g_sw
    assign lock_wr[k] = wr_acc & (req_addr_i == ADDR_W'(lock_ofs(k)));
    assign ctrl_wr[k] = wr_acc & (req_addr_i == ADDR_W'(ctrl_ofs(k)));

    rstc_swrst u_sw (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lock_wr_i (lock_wr[k]),
      .ctrl_wr_i (ctrl_wr[k]),
      .wbit_i    (req_wdata_i[0]),
      .lock_o    (lock_q[k]),
      .ctrl_o    (ctrl_q[k]),
      .rst_no    (periph_rst_no[k])
    );
  end

  rstc_rdmux #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .NUM_CAUSE (NUM_CAUSE),
    .NUM_SW    (NUM_SW)
  ) u_rdmux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_acc),
    .addr_i  (req_addr_i),
    .cause_i (cause_q),
    .lock_i  (lock_q),
    .ctrl_i  (ctrl_q),
    .rdata_o (rsp_rdata_o)
  );
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_CAUSE = 5,
  parameter int unsigned NUM_SW    = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_vld_i,
  input logic                 req_wr_i,
  input logic [NUM_CAUSE-1:0] cause_pulse_i,
  input logic [DATA_W-1:0]    rsp_rdata_o,
  input logic [NUM_SW-1:0]    periph_rst_no,
  input logic [NUM_CAUSE-1:0] cause_q,
  input logic [NUM_SW-1:0]    lock_q,
  input logic [NUM_SW-1:0]    ctrl_q
);
  AST_PULSE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cause_pulse_i) |=> ((cause_q & $past(cause_pulse_i)) == $past(cause_pulse_i))) else $error("pulse lost"); // R4

  AST_LOCK_NEVER_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lock_q & ~$past(lock_q)) == '0)) else $error("lock set again"); // R5

  AST_OUT_FOLLOWS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (periph_rst_no == $past(ctrl_q))) else $error("reset output lag"); // R8

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_vld_i && !req_wr_i) |=> (rsp_rdata_o == '0)) else $error("stray read data"); // R9

  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_rdata_o[DATA_W-1:NUM_CAUSE] == '0) else $error("unused bits set"); // R9

  for (genvar k = 0; k < NUM_SW; k++) begin : g_ch
    AST_CTRL_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ctrl_q[k]) |-> $past(lock_q[k])) else $error("locked control changed"); // R7
  end
endmodule

bind rstc_regs rstc_chk #(
  .DATA_W    (DATA_W),
  .NUM_CAUSE (NUM_CAUSE),
  .NUM_SW    (NUM_SW)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_vld_i     (req_vld_i),
  .req_wr_i      (req_wr_i),
  .cause_pulse_i (cause_pulse_i),
  .rsp_rdata_o   (rsp_rdata_o),
  .periph_rst_no (periph_rst_no),
  .cause_q       (cause_q),
  .lock_q        (lock_q),
  .ctrl_q        (ctrl_q)
);

// File: tb/sim_rstc_regs.sv
`timescale 1ns/1ps
module sim_rstc_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_vld_i, req_wr_i;
  logic [7:0]  req_addr_i;
  logic [31:0] req_wdata_i;
  logic [31:0] rsp_rdata_o;
  logic [4:0]  cause_pulse_i;
  logic [1:0]  periph_rst_no;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Behavioural reference state
  int m_cause;
  int m_lock [2];
  int m_ctrl [2];

  always #2.5 clk_i = ~clk_i;

  rstc_regs u0 (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_vld_i     (req_vld_i),
    .req_wr_i      (req_wr_i),
    .req_addr_i    (req_addr_i),
    .req_wdata_i   (req_wdata_i),
    .rsp_rdata_o   (rsp_rdata_o),
    .cause_pulse_i (cause_pulse_i),
    .periph_rst_no (periph_rst_no)
  );

  task automatic compare(input string tag, input int exp_rd, input int exp_out);
    n_cmp++;
    if (rsp_rdata_o !== 32'(exp_rd)) begin
      n_bad++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, rsp_rdata_o, 32'(exp_rd));
    end
    if (periph_rst_no !== 2'(exp_out)) begin
      n_bad++;
      $display("FAIL %s rst_n actual=%b expected=%b", tag, periph_rst_no, 2'(exp_out));
    end
  endtask

  function automatic int model_read(input int a);
    case (a)
      0:  return m_cause;
      4:  return m_lock[0];
      8:  return m_ctrl[0];
      12: return m_lock[1];
      16: return m_ctrl[1];
      default: return 0;
    endcase
  endfunction

  // One clock: drive, update model at the edge, compare at the falling edge
  task automatic step(input bit v, input bit w, input int a, input int d,
                      input int p, input string tag);
    int exp_rd, exp_out;
    req_vld_i = v; req_wr_i = w; req_addr_i = 8'(a);
    req_wdata_i = 32'(d); cause_pulse_i = 5'(p);
    @(posedge clk_i);
    exp_rd  = (v && !w) ? model_read(a) : 0;
    exp_out = (m_ctrl[1] << 1) | m_ctrl[0];
    if (v && w) begin
      case (a)
        0:  m_cause = m_cause & ~(d & 31);
        4:  if (d & 1) m_lock[0] = 0;
        8:  if (m_lock[0] == 1) m_ctrl[0] = d & 1;
        12: if (d & 1) m_lock[1] = 0;
        16: if (m_lock[1] == 1) m_ctrl[1] = d & 1;
        default: ;
      endcase
    end
    m_cause = m_cause | (p & 31);
    @(negedge clk_i);
    compare(tag, exp_rd, exp_out);
  endtask

  task automatic rd(input int a, input string tag);
    step(1, 0, a, 0, 0, tag);
  endtask

  task automatic wr(input int a, input int d, input string tag);
    step(1, 1, a, d, 0, tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    rst_ni = 1'b0; req_vld_i = 0; req_wr_i = 0; req_addr_i = '0;
    req_wdata_i = '0; cause_pulse_i = '0;
    m_cause = 1; m_lock[0] = 1; m_lock[1] = 1; m_ctrl[0] = 1; m_ctrl[1] = 1;
    repeat (3) @(negedge clk_i);
    compare("R1 in reset", 0, 3);
    rst_ni = 1'b1;
    idle("R1 after release");

    // R1: reset values of every register
    rd(0, "R1 cause"); rd(4, "R1 spi lock"); rd(8, "R1 spi ctrl");
    rd(12, "R1 usb lock"); rd(16, "R1 usb ctrl");

    // R2: single and multiple cause pulses, sticky
    step(0, 0, 0, 0, 5'h04, "R2 watchdog pulse");
    rd(0, "R2 watchdog flag");
    step(0, 0, 0, 0, 5'h18, "R2 two pulses");
    idle("R2 sticky"); idle("R2 sticky");
    rd(0, "R2 multiple flags");
    step(1, 0, 0, 0, 5'h02, "R2 R9 read during pulse");
    rd(0, "R2 lp exit flag");

    // R3: write one to clear
    wr(0, 0, "R3 zero write");
    rd(0, "R3 after zero write");
    wr(0, 32'h0000_0001, "R3 clear power-up");
    rd(0, "R3 after clear");
    wr(0, 32'hFFFF_FFE0, "R3 upper bits");
    rd(0, "R3 after upper bits");
    wr(0, 32'h0000_0018, "R3 clear two");
    rd(0, "R3 after clear two");

    // R4: pulse and clear on the same flag
    step(1, 1, 0, 32'h0000_0006, 5'h04, "R4 collide");
    rd(0, "R4 flag kept");

    // R10: unmapped offsets
    rd(20, "R10 past map"); rd(3, "R10 misaligned"); rd(255, "R10 top");
    wr(20, -1, "R10 write past map"); wr(6, -1, "R10 write misaligned");
    rd(0, "R10 cause intact"); rd(4, "R10 lock intact"); rd(8, "R10 ctrl intact");

    // R6, R8: control while unlocked
    wr(8, 0, "R6 spi hold");
    idle("R8 spi low"); idle("R8 spi low");
    rd(8, "R6 spi ctrl");
    wr(8, 32'h0000_0001, "R6 spi release");
    idle("R8 spi high");
    wr(16, 0, "R6 usb hold");
    idle("R8 usb low");
    wr(8, 0, "R6 spi hold again");
    idle("R8 both low");

    // R5, R7: locks
    wr(4, 0, "R5 zero write to lock");
    rd(4, "R5 lock still set");
    wr(4, 32'h0000_0001, "R5 clear spi lock");
    rd(4, "R5 spi lock cleared");
    wr(4, 32'h0000_0001, "R5 rewrite lock");
    wr(4, 0, "R5 no set");
    rd(4, "R5 lock stays clear");
    wr(8, 32'h0000_0001, "R7 locked spi write");
    idle("R7 spi still held");
    rd(8, "R7 spi ctrl frozen");
    wr(16, 32'h0000_0001, "R6 usb still writable");
    idle("R8 usb high");
    wr(12, 32'h0000_0003, "R5 clear usb lock");
    wr(16, 0, "R7 locked usb write");
    idle("R7 usb unchanged");
    rd(12, "R5 usb lock cleared"); rd(16, "R7 usb ctrl frozen");
    idle("R9 idle"); idle("R9 idle");

    finished = 1;
    summary();
  end
endmodule